// File: doc/BRIEF.md
# Paced Double-Edge Burst Transmitter

This block is the sending end of a paced transfer in which both edges of a free-running strobe carry data. Once started, it toggles its strobe line `req` on every transfer-period tick. Each edge of `req` presents one half-word on `data`, so every pair of periods (rising edge, then falling edge) moves one full double-width word taken from an upstream valid/ready stream.

There is no separate valid wire. Whether a pair carries real data is encoded on the `p1` line by its phase against the pair boundaries. While the data state stays the same, `p1` flips at every pair boundary. When the state changes, `p1` skips exactly one flip, which reverses its phase. The word source only needs to honour the handshake. The pacing tick comes from a period generator outside the block.

A stop request lets the current pair finish. After that, `req` stays low and the lines go quiet until the next start.

Top module: `pdt_tx`

## Requirements
- R1: After reset, `req`, `data`, `p1` and `word_ready` are all 0.
- R2: After `start` (while idle), `req` rises on the first `tick` and then inverts on every later `tick`. It changes at no other time.
- R3: `word_ready` is high only during a `tick` cycle that opens a pair, which is the tick on which `req` rises. An accepted word puts bits [15:0] on `data` with the rising edge and bits [31:16] with the following falling edge.
- R4: On the boundary where a word is accepted after an invalid pair (or after start), `p1` keeps its level. On each later boundary that also accepts a word, `p1` inverts.
- R5: `p1` changes only in the same cycle in which `req` rises.
- R6: A boundary that accepts no word makes the pair invalid, and `data` is 0 for both of its halves. On the first invalid boundary after valid data, `p1` keeps its level. On each later invalid boundary, `p1` inverts.
- R7: On the boundary right after entering the invalid state, `word_ready` stays low even if a word is offered. Therefore an invalid run lasts at least two pairs and contains at least one `p1` transition.
- R8: After `stop`, the pair in progress completes. From the next pair boundary on, `req` stays 0, `data` is 0, `p1` holds its level, and `word_ready` stays low until a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per transfer period |
| start | input | 1 | Begin pacing when idle |
| stop | input | 1 | End pacing after the current pair |
| word_valid | input | 1 | Upstream word present |
| word_data | input | 2*HALF_W | Upstream word, low half sent first |
| word_ready | output | 1 | Word taken this cycle when valid is also high |
| req | output | 1 | Free-running transfer strobe |
| data | output | HALF_W | Half-word on the bus |
| p1 | output | 1 | Phase-encoded data-valid line |

## Verification
The bench builds the block with HALF_W at 16. With that setting, the two halves of a 32-bit word are distinct and easy to check on the 16-bit bus. Ticks arrive every second clock, so a long sequence of pairs fits in a short run. That sequence covers valid runs, the forced two-pair gap, longer gaps, a stop issued in mid-pair, idle ticks afterwards and a restart. Together these reach every phase reversal of `p1`.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef enum logic {
        ST_INVALID = 1'b0,
        ST_VALID   = 1'b1
    } dstate_e;

    typedef struct packed {
        logic boundary;  // tick opening a pair while running
        logic second;    // tick opening the second half
        logic halt;      // boundary tick that ends the run
    } pace_s;

    // The phase line flips when the data state is unchanged across a boundary.
    // It holds when the state changes, which reverses its phase.
    function automatic logic p1_next(input logic was_valid,
                                     input logic now_valid,
                                     input logic cur);
        return (was_valid == now_valid) ? ~cur : cur;
    endfunction

endpackage

// File: rtl/pdt_pacer.sv
module pdt_pacer
    import pdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  start,
    input  logic  stop,
    output logic  req,
    output pace_s strobe
);
    logic  running;
    logic  stop_pend;
    half_e phase;

    always_comb begin
        strobe.boundary = running && tick && (phase == HALF_LO) && !stop_pend;
        strobe.second   = running && tick && (phase == HALF_HI);
        strobe.halt     = running && tick && (phase == HALF_LO) && stop_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
            phase     <= HALF_LO;
            req       <= 1'b0;
        end else if (!running) begin
            if (start) begin
                running   <= 1'b1;
                stop_pend <= 1'b0;
                phase     <= HALF_LO;
            end
        end else begin
            if (stop) stop_pend <= 1'b1;
            if (strobe.halt) begin
                running   <= 1'b0;
                stop_pend <= 1'b0;
            end else if (strobe.boundary) begin
                req   <= 1'b1;
                phase <= HALF_HI;
            end else if (strobe.second) begin
                req   <= 1'b0;
                phase <= HALF_LO;
            end
        end
    end

    // R2: the strobe only moves on a tick
    p_req_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(req));

    // R8: a run ends with the strobe already negated
    p_halt_req_low_r8: assert property (@(posedge clk) disable iff (rst)
        strobe.halt |-> !req);

endmodule

// File: rtl/pdt_p1_ctrl.sv
module pdt_p1_ctrl
    import pdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pace_s strobe,
    input  logic  word_valid,
    output logic  ready,
    output logic  take,
    output logic  p1
);
    dstate_e mode;
    logic    gap_done;   // invalid run has already spanned one full pair

    always_comb begin
        ready = strobe.boundary && ((mode == ST_VALID) || gap_done);
        take  = ready && word_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= ST_INVALID;
            gap_done <= 1'b1;
            p1       <= 1'b0;
        end else if (strobe.halt) begin
            mode     <= ST_INVALID;
            gap_done <= 1'b1;
        end else if (strobe.boundary) begin
            p1       <= p1_next(mode == ST_VALID, take, p1);
            mode     <= take ? ST_VALID : ST_INVALID;
            gap_done <= !take && (mode == ST_INVALID);
        end
    end

    // R4: entering the valid state withholds the phase flip
    p_hold_on_valid_entry_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mode == ST_VALID) |-> $stable(p1));

    // R6: leaving the valid state withholds the phase flip
    p_hold_on_invalid_entry_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(mode == ST_VALID) |-> $stable(p1));

    // R7: a return to valid data needs a completed gap pair
    p_gap_before_resume_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mode == ST_VALID) |-> $past(gap_done));

endmodule

// File: rtl/pdt_lanes.sv
module pdt_lanes
    import pdt_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  pace_s               strobe,
    input  logic                take,
    input  logic [2*HALF_W-1:0] word,
    output logic [HALF_W-1:0]   data
);
    logic [HALF_W-1:0] upper_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data    <= '0;
            upper_q <= '0;
        end else if (strobe.halt) begin
            data    <= '0;
            upper_q <= '0;
        end else if (strobe.boundary) begin
            data    <= take ? word[HALF_W-1:0]        : '0;
            upper_q <= take ? word[2*HALF_W-1:HALF_W] : '0;
        end else if (strobe.second) begin
            data    <= upper_q;
        end
    end

    // R8: the bus goes quiet when the run ends
    p_halt_clears_r8: assert property (@(posedge clk) disable iff (rst)
        strobe.halt |=> (data == '0));

    // R6: an empty boundary blanks the first half
    p_empty_pair_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe.boundary && !take) |=> (data == '0));

endmodule

// File: rtl/pdt_tx.sv
module pdt_tx
    import pdt_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic              stop,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              req,
    output logic [HALF_W-1:0] data,
    output logic              p1
);
    pace_s strobe;
    logic  take;

    pdt_pacer u_pacer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .start  (start),
        .stop   (stop),
        .req    (req),
        .strobe (strobe)
    );

    pdt_p1_ctrl u_phase (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .word_valid (word_valid),
        .ready      (word_ready),
        .take       (take),
        .p1         (p1)
    );

    pdt_lanes #(.HALF_W(HALF_W)) u_lanes (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .take   (take),
        .word   (word_data),
        .data   (data)
    );

    // R5: the phase line moves only together with a rising strobe
    p_p1_on_req_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (p1 != $past(p1)) |-> (req && !$past(req)));

    // R3: words are taken only on a tick that opens a pair
    p_ready_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        word_ready |-> (tick && !req));

endmodule

// File: tb/tb_pdt_tx.sv
module tb_pdt_tx;
    localparam int HALF_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic              word_valid = 1'b0;
    logic [2*HALF_W-1:0] word_data = '0;
    logic              word_ready;
    logic              req;
    logic [HALF_W-1:0] data;
    logic              p1;

    always #10 clk = ~clk;   // 50 MHz

    pdt_tx #(.HALF_W(HALF_W)) dut (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .stop(stop),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .req(req), .data(data), .p1(p1)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // scoreboard: {req, data, p1}
    logic [HALF_W+1:0] exp_q[$];
    string             tag_q[$];
    logic              tick_seen = 1'b0;

    always @(posedge clk) tick_seen <= tick;

    always @(negedge clk) begin
        if (tick_seen) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL monitor: output change with empty queue, act=%h exp=none",
                         {req, data, p1});
            end else begin
                logic [HALF_W+1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if ({req, data, p1} !== e) begin
                    n_bad++;
                    $display("FAIL %s: req/data/p1 act=%b/%h/%b exp=%b/%h/%b",
                             t, req, data, p1, e[HALF_W+1], e[HALF_W:1], e[0]);
                end
            end
        end
    end

    // reference model state
    bit                m_run = 0, m_stop = 0, m_hi = 0, m_valid = 0, m_gap = 1;
    logic              m_req = 0, m_p1 = 0;
    logic [HALF_W-1:0] m_data = '0, m_upper = '0;

    task automatic check_ready(input logic exp, input string t);
        n_cmp++;
        if (word_ready !== exp) begin
            n_bad++;
            $display("FAIL %s: word_ready act=%b exp=%b", t, word_ready, exp);
        end
    endtask

    task automatic period(input bit offer, input logic [2*HALF_W-1:0] w, input string t);
        logic rdy;
        bit   tk;
        rdy = 1'b0;
        if (m_run) begin
            if (!m_hi) begin
                if (m_stop) begin
                    m_run = 0; m_stop = 0; m_data = '0; m_upper = '0;
                    m_valid = 0; m_gap = 1;
                end else begin
                    rdy = m_valid || m_gap;
                    tk  = offer && rdy;
                    if (tk == m_valid) m_p1 = ~m_p1;
                    m_data  = tk ? w[HALF_W-1:0] : '0;
                    m_upper = tk ? w[2*HALF_W-1:HALF_W] : '0;
                    m_gap   = !tk && !m_valid;
                    m_valid = tk;
                    m_req   = 1'b1;
                    m_hi    = 1;
                end
            end else begin
                m_req  = 1'b0;
                m_data = m_upper;
                m_hi   = 0;
            end
        end
        exp_q.push_back({m_req, m_data, m_p1});
        tag_q.push_back(t);
        @(negedge clk);
        tick = 1'b1; word_valid = offer; word_data = w;
        #1;
        check_ready(rdy, t);
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; word_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (!m_run) begin m_run = 1; m_hi = 0; m_stop = 0; end
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        if (m_run) m_stop = 1;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, act=hung exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if ({req, data, p1, word_ready} !== '0) begin
            n_bad++;
            $display("FAIL R1: reset outputs act=%h exp=0", {req, data, p1, word_ready});
        end
        // idle ticks do nothing before start (R2)
        period(1, 32'hDEAD_BEEF, "R2 idle");
        do_start();
        period(1, 32'h1111_A0A0, "R4 entry hold");
        period(0, 32'h0,         "R3 upper half");
        period(1, 32'h2222_B1B1, "R4 flip");
        period(0, 32'h0,         "R3 upper half");
        period(1, 32'h3333_C2C2, "R4 flip");
        period(0, 32'h0,         "R2 falling");
        period(0, 32'h0,         "R6 invalid entry");
        period(0, 32'h0,         "R6 zero half");
        period(1, 32'h4444_D3D3, "R7 gap forced");
        period(0, 32'h0,         "R6 zero half");
        period(1, 32'h5555_E4E4, "R4 resume hold");
        period(0, 32'h0,         "R3 upper half");
        period(0, 32'h0,         "R6 invalid entry");
        period(0, 32'h0,         "R6 zero half");
        period(0, 32'h0,         "R6 gap flip");
        period(0, 32'h0,         "R6 zero half");
        period(0, 32'h0,         "R6 gap flip");
        period(0, 32'h0,         "R6 zero half");
        period(1, 32'h6666_F5F5, "R4 resume hold");
        period(0, 32'h0,         "R3 upper half");
        period(1, 32'h7777_0606, "R5 flip on rise");
        do_stop();
        period(0, 32'h0,         "R8 pair completes");
        period(1, 32'h8888_1717, "R8 halted");
        period(0, 32'h0,         "R8 quiet");
        period(1, 32'h9999_2828, "R8 quiet");
        do_start();
        period(1, 32'hAAAA_3939, "R2 restart");
        period(0, 32'h0,         "R3 upper half");
        period(1, 32'hBBBB_4A4A, "R4 flip");
        period(0, 32'h0,         "R3 upper half");
        repeat (4) @(posedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: pending expectations act=%0d exp=0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule